// File: doc/BRIEF.md
# Per-Core Mailbox Interrupt Channel

This block sits on the receive side of a multi-channel mailbox and serves one core. Every mailbox channel can raise two kinds of single-cycle event toward this core: a request (a sender asks for attention) and a done (a transfer on the channel has finished). The block collects these events into a 32-bit flag register. A flag mask register selects which events are recorded at all. An enable register selects which recorded flags drive the single level-sensitive interrupt line.

Software reaches the block through a small word-addressed register bus. Writes take effect in the cycle they are presented, and reads are combinational. Three lock bits in a control register protect the mask, enable and flag registers against stray writes. Software clears the relevant lock, performs its update, and sets the lock again. Flags are cleared by writing ones. A read-only status word shows the flags that are both set and enabled.

Top module: `mbi_channel`

## Requirements
- R1: The event vector places the request event of channel n (n = 0..15) at bit n and the done event of channel n at bit n+16. This layout is shared by the mask, enable, flag and status words.
- R2: An event sets its flag bit at the next clock edge only when the matching mask bit is set. Events on masked-off bits leave the flag register unchanged.
- R3: The control register has three lock bits: bit 0 locks the mask, bit 1 locks the enable, and bit 2 locks the flag register. Its other bits read as zero. The control register itself is always writable.
- R4: A write to the mask (address 1) or enable (address 2) register changes it only while its lock bit is clear. A locked write is dropped, and the bus still completes normally.
- R5: While the flag lock is set, a write to the flag register (address 3) clears nothing.
- R6: With the flag lock clear, writing 1 to a flag bit clears it and writing 0 leaves it unchanged.
- R7: The status word (address 4) reads as flag AND enable. Writes to it have no effect.
- R8: The interrupt output is high exactly when the status word is non-zero.
- R9: If an enabled event and a write-one-clear hit the same flag bit in the same cycle, the flag stays set.
- R10: After reset every register, including the lock bits, reads zero and the interrupt is low. Address 0 is the control register. Unused addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| req_evt | input | 16 | Request event pulses, one per channel |
| done_evt | input | 16 | Done event pulses, one per channel |
| irq | output | 1 | Level interrupt to the core |

## Verification
A write or an event presented before a rising edge is reflected in the registers right after that edge. A read is combinational, so it reflects the state in the same cycle its address is driven. The interrupt follows the flag and enable registers with no added register, so it changes after the same edge as the flags. The bench drives stimulus one nanosecond after a rising edge and holds it for exactly one cycle. Each read is queued with its expected word and interrupt level, and a monitor compares them on the following falling edge, when the register state from the last edge has settled.

// File: rtl/mbi_pkg.sv
package mbi_pkg;

    localparam int unsigned NUM_CH = 16;
    localparam int unsigned EVT_W  = 2 * NUM_CH;
    localparam int unsigned ADDR_W = 3;

    typedef logic [EVT_W-1:0]  evt_t;
    typedef logic [NUM_CH-1:0] chan_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_MASK = 3'd1,
        SEL_EN   = 3'd2,
        SEL_FLAG = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;

    // Bit order of the packed struct sets the control word layout:
    // bit 2 flag lock, bit 1 enable lock, bit 0 mask lock.
    typedef struct packed {
        logic flag_lk;
        logic en_lk;
        logic mask_lk;
    } lock_t;

    localparam int unsigned LOCK_W = $bits(lock_t);

    // Done events occupy the upper half, requests the lower half.
    function automatic evt_t join_events(chan_t req, chan_t done);
        return {done, req};
    endfunction

endpackage

// File: rtl/mbi_cfg_regs.sv
module mbi_cfg_regs
    import mbi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  reg_sel_e sel_i,
    input  evt_t     wdata_i,
    output lock_t    lock_o,
    output evt_t     mask_o,
    output evt_t     en_o
);

    lock_t lock_q;
    evt_t  mask_q;
    evt_t  en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
            mask_q <= '0;
            en_q   <= '0;
        end else if (wr_i) begin
            if (sel_i == SEL_CTRL) begin
                lock_q <= lock_t'(wdata_i[LOCK_W-1:0]);
            end
            if (sel_i == SEL_MASK && !lock_q.mask_lk) begin
                mask_q <= wdata_i;
            end
            if (sel_i == SEL_EN && !lock_q.en_lk) begin
                en_q <= wdata_i;
            end
        end
    end

    assign lock_o = lock_q;
    assign mask_o = mask_q;
    assign en_o   = en_q;

    p_mask_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel_i == SEL_MASK && lock_q.mask_lk) |=> $stable(mask_q));

    p_en_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel_i == SEL_EN && lock_q.en_lk) |=> $stable(en_q));

    p_other_sel_keeps_cfg_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_i || sel_i == SEL_FLAG || sel_i == SEL_STAT) |=> ($stable(mask_q) && $stable(en_q) && $stable(lock_q)));

endmodule

// File: rtl/mbi_flag_bank.sv
module mbi_flag_bank
    import mbi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt_i,
    input  evt_t mask_i,
    input  logic clr_wr_i,
    input  logic clr_lock_i,
    input  evt_t clr_bits_i,
    output evt_t flag_o
);

    evt_t flag_q;
    logic clr_ok;

    assign clr_ok = clr_wr_i && !clr_lock_i;

    for (genvar b = 0; b < EVT_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[b] <= 1'b0;
            end else if (evt_i[b] && mask_i[b]) begin
                flag_q[b] <= 1'b1;          // capture wins over a same-cycle clear
            end else if (clr_ok && clr_bits_i[b]) begin
                flag_q[b] <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;

    p_no_capture_unmasked_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(mask_i & evt_i)) == '0));

    p_locked_no_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_wr_i && clr_lock_i) |=> ((~flag_q & $past(flag_q)) == '0));

    p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
        ((evt_i & mask_i) != '0) |=> ((flag_q & $past(evt_i & mask_i)) == $past(evt_i & mask_i)));

endmodule

// File: rtl/mbi_rd_mux.sv
module mbi_rd_mux
    import mbi_pkg::*;
(
    input  reg_sel_e sel_i,
    input  lock_t    lock_i,
    input  evt_t     mask_i,
    input  evt_t     en_i,
    input  evt_t     flag_i,
    output evt_t     rdata_o
);

    always_comb begin
        unique case (sel_i)
            SEL_CTRL: rdata_o = evt_t'(lock_i);
            SEL_MASK: rdata_o = mask_i;
            SEL_EN:   rdata_o = en_i;
            SEL_FLAG: rdata_o = flag_i;
            SEL_STAT: rdata_o = flag_i & en_i;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/mbi_channel.sv
module mbi_channel
    import mbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [EVT_W-1:0]  bus_wdata,
    output logic [EVT_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] req_evt,
    input  logic [NUM_CH-1:0] done_evt,
    output logic              irq
);

    reg_sel_e sel;
    lock_t    lock;
    evt_t     mask;
    evt_t     en;
    evt_t     flag;
    evt_t     events;

    assign sel    = reg_sel_e'(bus_addr);
    assign events = join_events(req_evt, done_evt);

    mbi_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr),
        .sel_i   (sel),
        .wdata_i (bus_wdata),
        .lock_o  (lock),
        .mask_o  (mask),
        .en_o    (en)
    );

    mbi_flag_bank u_flags (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (events),
        .mask_i     (mask),
        .clr_wr_i   (bus_wr && sel == SEL_FLAG),
        .clr_lock_i (lock.flag_lk),
        .clr_bits_i (bus_wdata),
        .flag_o     (flag)
    );

    mbi_rd_mux u_rd (
        .sel_i   (sel),
        .lock_i  (lock),
        .mask_i  (mask),
        .en_i    (en),
        .flag_i  (flag),
        .rdata_o (bus_rdata)
    );

    assign irq = |(flag & en);

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag != '0 && en != '0));

    always_comb begin
        if (!rst && sel == SEL_STAT) begin
            p_irq_matches_status_r8: assert (irq == (bus_rdata != '0));
        end
    end

endmodule

// File: tb/tb_mbi_channel.sv
`timescale 1ns/1ps
module tb_mbi_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] req_evt = '0;
    logic [15:0] done_evt = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic probe = 1'b0;

    logic [31:0] q_data[$];
    logic        q_irq[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    mbi_channel dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_evt(req_evt), .done_evt(done_evt), .irq(irq)
    );

    // Driver: queue the expectation and present the read address for one cycle.
    task automatic expect_rd(input logic [2:0] a, input logic [31:0] d,
                             input logic i, input string tag);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = a;
        q_data.push_back(d); q_irq.push_back(i); q_tag.push_back(tag);
        probe = 1'b1;
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] r, input logic [15:0] dn);
        @(posedge clk); #1;
        req_evt = r; done_evt = dn;
        @(posedge clk); #1;
        req_evt = '0; done_evt = '0;
    endtask

    // Monitor: compare queued expectation against the settled outputs.
    always @(negedge clk) begin
        if (probe) begin
            logic [31:0] ed;
            logic        ei;
            string       t;
            ed = q_data.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
            checks++;
            if (bus_rdata !== ed || irq !== ei) begin
                errors++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         t, bus_rdata, irq, ed, ei);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10: reset state
        expect_rd(3'd0, 32'h0, 1'b0, "R10 ctrl");
        expect_rd(3'd1, 32'h0, 1'b0, "R10 mask");
        expect_rd(3'd2, 32'h0, 1'b0, "R10 enable");
        expect_rd(3'd3, 32'h0, 1'b0, "R10 flag");
        expect_rd(3'd4, 32'h0, 1'b0, "R10 status");
        expect_rd(3'd6, 32'h0, 1'b0, "R10 unused address");

        // R4 unlocked writes; R1/R2 capture layout and masking
        wr(3'd1, 32'h0001_0003);
        wr(3'd2, 32'hFFFF_FFFF);
        expect_rd(3'd1, 32'h0001_0003, 1'b0, "R4 mask write unlocked");
        pulse(16'h0005, 16'h0003);
        expect_rd(3'd3, 32'h0001_0001, 1'b1, "R1 R2 flag capture");
        expect_rd(3'd4, 32'h0001_0001, 1'b1, "R7 R8 status and irq");

        // R6 write-one-clear
        wr(3'd3, 32'h0000_0001);
        expect_rd(3'd3, 32'h0001_0000, 1'b1, "R6 clear one bit");

        // R3 lock bits
        wr(3'd0, 32'hFFFF_FFFF);
        expect_rd(3'd0, 32'h0000_0007, 1'b1, "R3 ctrl readback");
        wr(3'd1, 32'h0);
        expect_rd(3'd1, 32'h0001_0003, 1'b1, "R4 mask locked");
        wr(3'd2, 32'h0);
        expect_rd(3'd2, 32'hFFFF_FFFF, 1'b1, "R4 enable locked");
        wr(3'd3, 32'hFFFF_FFFF);
        expect_rd(3'd3, 32'h0001_0000, 1'b1, "R5 flag locked");

        // Unlock, narrow enables: status masks flags, irq drops
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h0000_FFFF);
        expect_rd(3'd4, 32'h0, 1'b0, "R7 R8 status gated by enable");
        expect_rd(3'd3, 32'h0001_0000, 1'b0, "R7 flag kept");
        wr(3'd4, 32'hFFFF_FFFF);
        expect_rd(3'd3, 32'h0001_0000, 1'b0, "R7 status write ignored");

        // R9 event and clear in one cycle
        wr(3'd2, 32'hFFFF_FFFF);
        @(posedge clk); #1;
        req_evt = 16'h0002; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0001_0002;
        @(posedge clk); #1;
        req_evt = '0; bus_wr = 1'b0;
        expect_rd(3'd3, 32'h0000_0002, 1'b1, "R9 event wins over clear");

        // R2 all events masked off
        wr(3'd1, 32'h0);
        pulse(16'hFFFF, 16'hFFFF);
        expect_rd(3'd3, 32'h0000_0002, 1'b1, "R2 masked events ignored");
        wr(3'd3, 32'h0000_0002);
        expect_rd(3'd4, 32'h0, 1'b0, "R6 R8 all cleared");

        @(posedge clk); #1;
        checks++;
        if (q_data.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: pending=%0d expected=0", q_data.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule